// File: doc/BRIEF.md
# Serial Clock-Freeze Controller

This block sits next to a clock buffer's output dividers and decides which output clocks actually toggle. A host drives a two-wire link: a free-running serial clock and a data line. A frame opens with a single low start bit and then carries twelve enable bits. Once the last of them arrives, the new word takes effect. Each of the twelve gated clocks then stops or restarts.

Twelve clocks can be gated: four in bank A, four in bank B, outputs 1 to 3 of bank C, and the synchronisation pulse. Two clocks bypass the gating entirely and always run: bank C output 0 and the feedback clock. Removing them from the gating means a corrupted frame can never stop the feedback loop.

Each gate moves its enable bit into the domain of the clock it controls. It changes the gate only while that clock is low. A clock therefore stops after a complete high phase and restarts with a complete one. A stopped output rests at logic 0.

Top module: `freeze_ctrl`

## Requirements
- R1: After reset every enable bit is 1, so all twelve gated outputs toggle with their input clocks, and the receiver waits for a start bit.
- R2: While the receiver is waiting, a high level on the data line is ignored. No frame begins and the outputs keep their current state for any number of idle serial clocks.
- R3: The data line is sampled on the rising edge of the serial clock. A frame is one 0 start bit followed by twelve bits. The first data bit after the start bit is bit 0 of the word, and the last is bit 11.
- R4: Word bit i controls gated output i. Bits 0-3 control bank A outputs 0-3, bits 4-7 control bank B outputs 0-3, bits 8-10 control bank C outputs 1-3, and bit 11 controls the synchronisation output.
- R5: A word bit of 1 lets its output follow its input clock. A bit of 0 freezes the output at logic 0.
- R6: Bank C output 0 and the feedback output follow their input clocks at all times, whatever word has been loaded.
- R7: Every high pulse on a gated output lasts exactly one full high phase of its input clock, including the pulses just before a freeze and just after an unfreeze.
- R8: A new word changes nothing until its twelfth data bit has been sampled. Up to that point, the outputs keep following the previous word.
- R9: After the twelfth data bit the receiver returns to waiting. A start bit on the very next serial clock opens a new frame, which loads normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Free-running serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdata | input | 1 | Serial data line, sampled on rising sclk |
| clk_in | input | 12 | Clocks to be gated, index = word bit |
| c0_in | input | 1 | Bank C output 0 source clock |
| fb_in | input | 1 | Feedback source clock |
| clk_out | output | 12 | Gated clocks |
| c0_out | output | 1 | Always-running bank C output 0 |
| fb_out | output | 1 | Always-running feedback output |

## Verification
The bench targets the points where a gated clock changes state. It measures the width of every high pulse on all twelve outputs across many freeze and unfreeze frames. A gate that switched while its clock was high would leave a shortened pulse. The bench also sends asymmetric words: a shifter that reversed the bit order, or dropped the start bit, would freeze the wrong outputs. While a frame is still arriving, the bench counts edges on the outputs. A design that applied bits one at a time would stop some of them early. Finally, two frames are sent back to back with no idle bit between them. A receiver that needed an idle high level before the next start bit would miss the second word.

// File: rtl/freeze_pkg.sv
package freeze_pkg;

  typedef enum logic {
    RX_WAIT = 1'b0,
    RX_BITS = 1'b1
  } rx_state_e;

  // counter width able to index n bit slots
  function automatic int cnt_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/freeze_serial_rx.sv
module freeze_serial_rx
  import freeze_pkg::*;
#(
  parameter int N_BITS = 12,
  localparam int CNT_W = cnt_bits(N_BITS)
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              sdata,
  output logic [N_BITS-1:0] word_o,
  output logic              busy_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              done_o
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(N_BITS - 1);

  rx_state_e               state_q;
  logic [CNT_W-1:0]        cnt_q;
  logic [N_BITS-2:0]       shreg_q;
  logic [N_BITS-1:0]       word_q;

  function automatic logic is_last(input logic [CNT_W-1:0] c);
    return c == LAST_IDX;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  // earliest bit ends up at index 0 after N_BITS-1 right shifts
  function automatic logic [N_BITS-1:0] assemble(input logic [N_BITS-2:0] sh,
                                                  input logic          msb);
    return {msb, sh};
  endfunction

  assign done_o = (state_q == RX_BITS) && is_last(cnt_q);
  assign busy_o = (state_q == RX_BITS);
  assign cnt_o  = cnt_q;
  assign word_o = word_q;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_WAIT;
      cnt_q   <= '0;
      shreg_q <= '0;
      word_q  <= '1;
    end else begin
      unique case (state_q)
        RX_WAIT: begin
          if (!sdata) begin
            state_q <= RX_BITS;
            cnt_q   <= '0;
          end
        end
        RX_BITS: begin
          if (is_last(cnt_q)) begin
            word_q  <= assemble(shreg_q, sdata);
            state_q <= RX_WAIT;
            cnt_q   <= '0;
          end else begin
            shreg_q <= {sdata, shreg_q[N_BITS-2:1]};
            cnt_q   <= cnt_next(cnt_q);
          end
        end
        default: state_q <= RX_WAIT;
      endcase
    end
  end

endmodule

// File: rtl/freeze_clk_gate.sv
module freeze_clk_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic en_i,
  output logic clk_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   en_low_q;

  // bring the enable into the gated clock's domain
  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= en_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], en_i};
      end
    end
  endgenerate

  // update only on the falling edge so the gate changes while the clock is low
  always_ff @(negedge clk_i or negedge rst_n) begin
    if (!rst_n) en_low_q <= 1'b1;
    else        en_low_q <= sync_q[SYNC_STAGES-1];
  end

  assign clk_o = clk_i & en_low_q;

endmodule

// File: rtl/freeze_ctrl.sv
module freeze_ctrl
  import freeze_pkg::*;
#(
  parameter int N_GATED     = 12,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = cnt_bits(N_GATED)
) (
  input  logic               sclk,
  input  logic               rst_n,
  input  logic               sdata,
  input  logic [N_GATED-1:0] clk_in,
  input  logic               c0_in,
  input  logic               fb_in,
  output logic [N_GATED-1:0] clk_out,
  output logic               c0_out,
  output logic               fb_out
);

  logic [N_GATED-1:0] enable_word;
  logic               rx_busy;
  logic [CNT_W-1:0]   rx_cnt;
  logic               frame_done;

  freeze_serial_rx #(.N_BITS(N_GATED)) rx_i (
    .sclk   (sclk),
    .rst_n  (rst_n),
    .sdata  (sdata),
    .word_o (enable_word),
    .busy_o (rx_busy),
    .cnt_o  (rx_cnt),
    .done_o (frame_done)
  );

  for (genvar g = 0; g < N_GATED; g++) begin : g_gate
    freeze_clk_gate #(.SYNC_STAGES(SYNC_STAGES)) gate_i (
      .clk_i (clk_in[g]),
      .rst_n (rst_n),
      .en_i  (enable_word[g]),
      .clk_o (clk_out[g])
    );
  end

  // exempt outputs: never gated
  assign c0_out = c0_in;
  assign fb_out = fb_in;

endmodule

// File: rtl/freeze_ctrl_chk.sv
module freeze_ctrl_chk #(
  parameter int N_GATED = 12,
  parameter int CNT_W   = 4
) (
  input logic               sclk,
  input logic               rst_n,
  input logic               sdata,
  input logic               rx_busy,
  input logic [CNT_W-1:0]   rx_cnt,
  input logic               frame_done,
  input logic [N_GATED-1:0] enable_word
);

  AST_START_OPENS_FRAME: assert property (@(posedge sclk) disable iff (!rst_n)
    (!rx_busy && !sdata) |=> (rx_busy && rx_cnt == '0)); // R3

  AST_IDLE_HIGH_IGNORED: assert property (@(posedge sclk) disable iff (!rst_n)
    (!rx_busy && sdata) |=> (!rx_busy && $stable(enable_word))); // R2

  AST_WORD_HELD_MID_FRAME: assert property (@(posedge sclk) disable iff (!rst_n)
    !frame_done |=> $stable(enable_word)); // R8

  AST_BIT_COUNT_STEPS: assert property (@(posedge sclk) disable iff (!rst_n)
    (rx_busy && !frame_done) |=> (rx_busy && rx_cnt == CNT_W'($past(rx_cnt) + 1'b1))); // R3

  AST_FRAME_RETURNS_IDLE: assert property (@(posedge sclk) disable iff (!rst_n)
    frame_done |=> !rx_busy); // R9

endmodule

bind freeze_ctrl freeze_ctrl_chk #(.N_GATED(N_GATED), .CNT_W(CNT_W)) chk_i (
  .sclk        (sclk),
  .rst_n       (rst_n),
  .sdata       (sdata),
  .rx_busy     (rx_busy),
  .rx_cnt      (rx_cnt),
  .frame_done  (frame_done),
  .enable_word (enable_word)
);

// File: tb/freeze_ctrl_tb.sv
`timescale 1ns/1ps
module freeze_ctrl_tb_top;

  localparam int N = 12;

  logic         sclk  = 1'b0;
  logic         rst_n = 1'b0;
  logic         sdata = 1'b1;
  logic         c0_in = 1'b0;
  logic         fb_in = 1'b0;
  wire  [N-1:0] clk_in;
  wire  [N-1:0] clk_out;
  wire          c0_out;
  wire          fb_out;

  freeze_ctrl dut_i (
    .sclk    (sclk),
    .rst_n   (rst_n),
    .sdata   (sdata),
    .clk_in  (clk_in),
    .c0_in   (c0_in),
    .fb_in   (fb_in),
    .clk_out (clk_out),
    .c0_out  (c0_out),
    .fb_out  (fb_out)
  );

  always #10 sclk  = ~sclk;   // 50 MHz serial clock
  always #4  c0_in = ~c0_in;
  always #5  fb_in = ~fb_in;

  function automatic int half_of(input int g);
    return 3 + (g % 4);
  endfunction

  int edges [N];
  int runts [N];
  int c0_edges = 0;
  int fb_edges = 0;

  for (genvar g = 0; g < N; g++) begin : g_ch
    logic    ck     = 1'b0;
    realtime rise_t = 0.0;
    initial forever #(half_of(g)) ck = ~ck;
    assign clk_in[g] = ck;
    always @(posedge clk_out[g]) begin
      edges[g] = edges[g] + 1;
      rise_t   = $realtime;
    end
    // R7: every high pulse must be one full high phase of the source
    always @(negedge clk_out[g]) begin
      realtime w;
      if (rise_t > 0.0) begin
        w = $realtime - rise_t;
        if (w < half_of(g) - 0.01 || w > half_of(g) + 0.01) runts[g] = runts[g] + 1;
      end
    end
  end

  always @(posedge c0_out) c0_edges++;
  always @(posedge fb_out) fb_edges++;

  int n_checks = 0;
  int n_fail   = 0;
  logic [N-1:0] exp_q [$];
  string        tag_q [$];
  bit           mon_busy = 1'b0;
  logic [N-1:0] cur_word = '1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pop expected word, let it settle, then observe edges per output
  initial begin
    int e0 [N];
    int c0s, fbs;
    logic [N-1:0] w;
    string t;
    forever begin
      wait (exp_q.size() > 0);
      mon_busy = 1'b1;
      w = exp_q.pop_front();
      t = tag_q.pop_front();
      repeat (4) @(posedge sclk);
      #3;
      for (int g = 0; g < N; g++) e0[g] = edges[g];
      c0s = c0_edges;
      fbs = fb_edges;
      #200;
      for (int g = 0; g < N; g++) begin
        if (w[g]) // enabled output follows its clock (R4, R5)
          chk(edges[g] - e0[g] > 0, t, $sformatf("out%0d running edges", g),
              edges[g] - e0[g], 1);
        else      // frozen output sits low (R4, R5)
          chk(edges[g] == e0[g] && clk_out[g] == 1'b0, t,
              $sformatf("out%0d frozen edges/level", g), edges[g] - e0[g], 0);
      end
      chk(c0_edges - c0s > 0, "R6", "c0 always runs", c0_edges - c0s, 1);
      chk(fb_edges - fbs > 0, "R6", "fb always runs", fb_edges - fbs, 1);
      mon_busy = 1'b0;
    end
  end

  // driver: start bit then D0..D11; optionally checks that the old word holds
  task automatic send_bits(input logic [N-1:0] word, input bit mid);
    int e0 [N];
    @(negedge sclk) sdata = 1'b0;
    for (int i = 0; i < N; i++) begin
      @(negedge sclk) sdata = word[i];
      if (mid && i == 4) for (int g = 0; g < N; g++) e0[g] = edges[g];
      if (mid && i == N - 1) begin
        for (int g = 0; g < N; g++) begin
          if (cur_word[g])
            chk(edges[g] - e0[g] > 0, "R8", $sformatf("out%0d old word mid-frame", g),
                edges[g] - e0[g], 1);
          else
            chk(edges[g] == e0[g], "R8", $sformatf("out%0d old freeze mid-frame", g),
                edges[g] - e0[g], 0);
        end
      end
    end
    cur_word = word;
  endtask

  task automatic expect_now(input logic [N-1:0] word, input string tag);
    exp_q.push_back(word);
    tag_q.push_back(tag);
    wait (exp_q.size() == 0);
    #1;
    wait (!mon_busy);
  endtask

  task automatic frame(input logic [N-1:0] word, input bit mid, input string tag);
    send_bits(word, mid);
    @(negedge sclk) sdata = 1'b1;
    expect_now(word, tag);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #3_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (5) @(posedge sclk);
    @(negedge sclk) rst_n = 1'b1;
    expect_now('1, "R1");                // reset: all run
    frame(12'h000, 1'b0, "R5");          // freeze all
    frame(12'hFFF, 1'b0, "R5");          // release all
    frame(12'h001, 1'b0, "R3");          // only first data bit set
    frame(12'h5A3, 1'b0, "R4");          // asymmetric pattern
    frame(12'h7FF, 1'b0, "R4");          // only sync output frozen
    frame(12'h0F0, 1'b0, "R4");          // only bank B runs
    frame(12'hF0F, 1'b1, "R8");          // old word held until last bit
    repeat (40) @(negedge sclk) sdata = 1'b1;
    expect_now(cur_word, "R2");          // idle high changes nothing
    send_bits(12'h3C3, 1'b0);            // back-to-back frames
    send_bits(12'hC3C, 1'b0);
    @(negedge sclk) sdata = 1'b1;
    expect_now(12'hC3C, "R9");
    for (int k = 0; k < 6; k++) begin    // toggling stress for R7
      send_bits((k % 2) ? 12'hAAA : 12'h555, 1'b0);
      @(negedge sclk) sdata = 1'b1;
      repeat (3) @(negedge sclk);
    end
    frame(12'hFFF, 1'b0, "R5");
    for (int g = 0; g < N; g++)
      chk(runts[g] == 0, "R7", $sformatf("out%0d partial pulses", g), runts[g], 0);
    finish_run();
  end

endmodule